// File: doc/BRIEF.md
# Shared Tagged Receive Queue

This block merges the characters delivered by four serial receivers into a single first-in first-out store of 64 entries. Each receiver hands over a finished character with a one-cycle strobe, together with its framing and parity error bits and a code for the character width. Every line has its own one-character holding slot. A scanner moves held characters into the shared store, one per cycle. Each stored entry is tagged with the number of the line it came from, its error flags, and an overrun flag for characters that were lost before the scanner reached them.

Software consumes the queue through one 16-bit read word that describes itself. It has a valid bit, three error flags, the line number and the character. A read strobe consumes the presented word. A receiver-done output shows that a valid word is presented, and an interrupt request follows it when enabled. After each read, done is held low for a fixed gap even if more entries are waiting, so a slow poll of the flag cannot mistake the old state for new data. Dropping the master scan enable, or pulsing master clear, throws away everything queued.

Top module: `rxq_top`

## Requirements
- R1: After reset, `rdWord` is 16'h0000 and `rxDone` and `rxIrq` are low.
- R2: The read word places the valid flag at bit 15, overrun at bit 14, framing error at bit 13 and parity error at bit 12. Bits 11:10 read zero, bits 9:8 hold the line number and bits 7:0 hold the character.
- R3: The 2-bit width code of each line selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Stored characters are right-justified, and the bits above the selected width read zero.
- R4: Entries come out in the order they were accepted. The store holds 64 entries in addition to the one word that is presented.
- R5: A read when `rxDone` is low returns bit 15 at zero and changes no state.
- R6: A read of a valid word drops `rxDone` on the next cycle. `rxDone` then stays low for at least `GAP_CYCLES` cycles, and it rises again within `GAP_CYCLES`+2 cycles if entries remain.
- R7: `rxIrq` is high exactly when `rxDone` and `rxIntEn` are both high.
- R8: When several lines offer characters in the same cycle, they are stored in ascending order of line number.
- R9: A character that arrives on a line whose slot still holds an unaccepted character replaces it. The entry that results carries overrun = 1. The next clean character on that line carries overrun = 0.
- R10: When the store is full, an arriving character waits in its line's slot. It is stored once space frees up and is not dropped.
- R11: While `scanEn` is low, the store and the slots are emptied, `rxDone` is low and strobes are ignored. Nothing reappears when `scanEn` returns high.
- R12: `masterClr` empties the store and the slots and clears bit 15 of `rdWord`, while bits 14:0 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStrobe | input | 4 | Character-ready strobe, one bit per line |
| lineData | input | 32 | Received characters, line n at bits 8n+7:8n |
| lineLen | input | 8 | Width codes, line n at bits 2n+1:2n |
| lineFerr | input | 4 | Framing error, one bit per line |
| linePerr | input | 4 | Parity error, one bit per line |
| rdStrobe | input | 1 | Consumes the presented word |
| scanEn | input | 1 | Master scan enable |
| rxIntEn | input | 1 | Receive interrupt enable |
| masterClr | input | 1 | Master clear pulse |
| rdWord | output | 16 | Presented read word |
| rxDone | output | 1 | A valid word is presented |
| rxIrq | output | 1 | Interrupt request |

## Verification
The assertions assume that each receiver raises its strobe for single cycles and keeps its data and error bits stable while the strobe is high. They also assume that `masterClr` is a short pulse and that the read strobe is a one-cycle pulse. The bench's pulse and read tasks drive every strobe for exactly one cycle, starting on a falling edge. All data lines are set before a strobe rises, and no input is changed on a rising edge. Overrun and full-store cases are produced on purpose, by back-to-back strobes on one line and by filling the store from a single line, rather than by abusing these input rules.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NLINES = 4;
  localparam int LINE_W = 2;
  localparam int CHAR_W = 8;
  localparam int LEN_W  = 2;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] chr;
  } entry_t;

  typedef struct packed {
    logic              push;
    logic [LINE_W-1:0] pushLine;
    logic              load;
    logic              flush;
  } ctl_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int GAP_CYCLES = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int GW = $clog2(GAP_CYCLES + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NLINES-1:0] holdValid,
  input  logic              rdStrobe,
  input  logic              scanEn,
  input  logic              masterClr,
  output ctl_t              ctl,
  output logic [AW-1:0]     wrAddr,
  output logic [AW-1:0]     rdAddr,
  output logic              outValid
);
  logic [CW-1:0]     count;
  logic [GW-1:0]     gapCnt;
  logic              anyReq;
  logic [LINE_W-1:0] winner;
  logic              fifoFull;
  logic              fifoEmpty;
  logic              consume;

  // fixed priority: lowest line number wins
  always_comb begin
    anyReq = 1'b0;
    winner = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (holdValid[i]) begin
        anyReq = 1'b1;
        winner = LINE_W'(i);
      end
    end
  end

  assign fifoFull  = (count == CW'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign consume   = rdStrobe && outValid;

  always_comb begin
    ctl.flush    = masterClr || !scanEn;
    ctl.push     = anyReq && !fifoFull && !ctl.flush;
    ctl.pushLine = winner;
    ctl.load     = !outValid && !fifoEmpty && (gapCnt == '0) && !ctl.flush;
  end

  function automatic logic [AW-1:0] nextAddr(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      wrAddr   <= '0;
      rdAddr   <= '0;
      outValid <= 1'b0;
      gapCnt   <= '0;
    end else if (ctl.flush) begin
      count    <= '0;
      rdAddr   <= wrAddr;
      outValid <= 1'b0;
      gapCnt   <= '0;
    end else begin
      if (ctl.push) wrAddr <= nextAddr(wrAddr);
      if (ctl.load) rdAddr <= nextAddr(rdAddr);
      count <= count + CW'(ctl.push) - CW'(ctl.load);
      if (consume) begin
        outValid <= 1'b0;
        gapCnt   <= GW'(GAP_CYCLES);
      end else begin
        if (ctl.load) outValid <= 1'b1;
        if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      end
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r4_load_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(count) != '0);
  a_r6_read_drops_done: assert property (@(posedge clk) disable iff (!rstN)
    consume |=> !outValid);
  a_r6_gap_keeps_done_low: assert property (@(posedge clk) disable iff (!rstN)
    (gapCnt != '0) |-> !outValid);
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (count == '0) && !outValid);
endmodule

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NLINES-1:0]        lineStrobe,
  input  logic [NLINES*CHAR_W-1:0] lineData,
  input  logic [NLINES*LEN_W-1:0]  lineLen,
  input  logic [NLINES-1:0]        lineFerr,
  input  logic [NLINES-1:0]        linePerr,
  input  ctl_t                     ctl,
  input  logic [AW-1:0]            wrAddr,
  input  logic [AW-1:0]            rdAddr,
  output logic [NLINES-1:0]        holdValid,
  output entry_t                   headEntry
);
  entry_t slotArr [NLINES];
  entry_t mem [DEPTH];

  for (genvar i = 0; i < NLINES; i++) begin : gLine
    logic              v;
    entry_t            slot;
    logic              taken;
    logic [CHAR_W-1:0] mask;

    assign taken = ctl.push && (ctl.pushLine == LINE_W'(i));
    // width code 0..3 keeps 5..8 low bits
    assign mask  = {CHAR_W{1'b1}} >> (LEN_W'(3) - lineLen[LEN_W*i +: LEN_W]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        v    <= 1'b0;
        slot <= '0;
      end else if (ctl.flush) begin
        v        <= 1'b0;
        slot.ovr <= 1'b0;
      end else if (lineStrobe[i]) begin
        v         <= 1'b1;
        slot.chr  <= lineData[CHAR_W*i +: CHAR_W] & mask;
        slot.ferr <= lineFerr[i];
        slot.perr <= linePerr[i];
        slot.line <= LINE_W'(i);
        slot.ovr  <= v && !taken;
      end else if (taken) begin
        v <= 1'b0;
      end
    end

    assign holdValid[i] = v;
    assign slotArr[i]   = slot;

    a_r9_overrun_marked: assert property (@(posedge clk) disable iff (!rstN)
      (lineStrobe[i] && v && !taken && !ctl.flush) |=> slot.ovr);
  end

  always_ff @(posedge clk) begin
    if (ctl.push) mem[wrAddr] <= slotArr[ctl.pushLine];
  end

  // presented fields survive flush and master clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         headEntry <= '0;
    else if (ctl.load) headEntry <= mem[rdAddr];
  end

  a_r11_slots_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> holdValid == '0);
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int GAP_CYCLES = 32,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NLINES-1:0]        lineStrobe,
  input  logic [NLINES*CHAR_W-1:0] lineData,
  input  logic [NLINES*LEN_W-1:0]  lineLen,
  input  logic [NLINES-1:0]        lineFerr,
  input  logic [NLINES-1:0]        linePerr,
  input  logic                     rdStrobe,
  input  logic                     scanEn,
  input  logic                     rxIntEn,
  input  logic                     masterClr,
  output logic [15:0]              rdWord,
  output logic                     rxDone,
  output logic                     rxIrq
);
  ctl_t              ctl;
  logic [AW-1:0]     wrAddr;
  logic [AW-1:0]     rdAddr;
  logic [NLINES-1:0] holdValid;
  logic              outValid;
  entry_t            headEntry;

  rxq_ctrl #(.DEPTH(DEPTH), .GAP_CYCLES(GAP_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .holdValid(holdValid), .rdStrobe(rdStrobe),
    .scanEn(scanEn), .masterClr(masterClr), .ctl(ctl), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .outValid(outValid)
  );

  rxq_data #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineData(lineData),
    .lineLen(lineLen), .lineFerr(lineFerr), .linePerr(linePerr), .ctl(ctl),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .holdValid(holdValid), .headEntry(headEntry)
  );

  assign rdWord = {outValid, headEntry.ovr, headEntry.ferr, headEntry.perr, 2'b00,
                   headEntry.line, headEntry.chr};
  assign rxDone = outValid;
  assign rxIrq  = outValid && rxIntEn;

  a_r11_scan_off_no_done: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> !rxDone);
  a_r12_clear_keeps_fields: assert property (@(posedge clk) disable iff (!rstN)
    masterClr |=> !rdWord[15] && (rdWord[14:0] == $past(rdWord[14:0])));
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
  localparam int GAP = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  lineStrobe = '0;
  logic [31:0] lineData = '0;
  logic [7:0]  lineLen = '0;
  logic [3:0]  lineFerr = '0;
  logic [3:0]  linePerr = '0;
  logic        rdStrobe = 1'b0;
  logic        scanEn = 1'b0;
  logic        rxIntEn = 1'b0;
  logic        masterClr = 1'b0;
  logic [15:0] rdWord;
  logic        rxDone;
  logic        rxIrq;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  rxq_top #(.DEPTH(64), .GAP_CYCLES(GAP)) u0 (
    .clk(clk), .rstN(rstN), .lineStrobe(lineStrobe), .lineData(lineData),
    .lineLen(lineLen), .lineFerr(lineFerr), .linePerr(linePerr),
    .rdStrobe(rdStrobe), .scanEn(scanEn), .rxIntEn(rxIntEn),
    .masterClr(masterClr), .rdWord(rdWord), .rxDone(rxDone), .rxIrq(rxIrq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setLine(input int ln, input logic [7:0] d, input logic [1:0] len,
                         input logic fe, input logic pe);
    lineData[8*ln +: 8] = d;
    lineLen[2*ln +: 2]  = len;
    lineFerr[ln]        = fe;
    linePerr[ln]        = pe;
  endtask

  task automatic pulse(input logic [3:0] m);
    lineStrobe = m;
    @(negedge clk);
    lineStrobe = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readWord(output logic [15:0] w);
    w = rdWord;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic nextWord(output logic [15:0] w);
    for (int k = 0; k < 3 * GAP + 8 && !rxDone; k++) @(negedge clk);
    readWord(w);
  endtask

  task automatic tReset;
    check("R1 reset word", rdWord, 16'h0000);
    check("R1 reset done", {15'd0, rxDone}, 16'd0);
    check("R1 reset irq", {15'd0, rxIrq}, 16'd0);
  endtask

  task automatic tFormat;
    logic [15:0] w;
    setLine(2, 8'hA5, 2'd3, 1'b0, 1'b1);
    rxIntEn = 1'b1;
    pulse(4'b0100);
    idle(4);
    check("R7 irq with enable", {15'd0, rxIrq}, 16'd1);
    rxIntEn = 1'b0;
    idle(1);
    check("R7 irq masked", {15'd0, rxIrq}, 16'd0);
    rxIntEn = 1'b1;
    readWord(w);
    check("R2 layout parity line2", w, 16'h92A5);
    check("R7 irq after read", {15'd0, rxIrq}, 16'd0);
    rxIntEn = 1'b0;
    setLine(1, 8'hFF, 2'd0, 1'b1, 1'b0);
    pulse(4'b0010);
    nextWord(w);
    check("R3 five-bit framing line1", w, 16'hA11F);
    setLine(0, 8'hFF, 2'd2, 1'b0, 1'b0);
    pulse(4'b0001);
    nextWord(w);
    check("R3 seven-bit line0", w, 16'h807F);
  endtask

  task automatic tEmpty;
    logic [15:0] w;
    idle(GAP + 4);
    readWord(w);
    check("R5 empty read valid", {15'd0, w[15]}, 16'd0);
    idle(3);
    check("R5 done after empty read", {15'd0, rxDone}, 16'd0);
  endtask

  task automatic tGap;
    logic [15:0] w;
    setLine(0, 8'h10, 2'd3, 1'b0, 1'b0);
    pulse(4'b0001);
    idle(2);
    setLine(0, 8'h11, 2'd3, 1'b0, 1'b0);
    pulse(4'b0001);
    nextWord(w);
    check("R4 gap first", w, 16'h8010);
    check("R6 done drops", {15'd0, rxDone}, 16'd0);
    idle(GAP);
    check("R6 done low through gap", {15'd0, rxDone}, 16'd0);
    idle(2);
    check("R6 done back", {15'd0, rxDone}, 16'd1);
    readWord(w);
    check("R4 gap second", w, 16'h8011);
  endtask

  task automatic tArb;
    logic [15:0] w;
    setLine(3, 8'h33, 2'd3, 1'b0, 1'b0);
    setLine(1, 8'h31, 2'd3, 1'b0, 1'b0);
    setLine(0, 8'h30, 2'd3, 1'b0, 1'b0);
    pulse(4'b1011);
    nextWord(w);
    check("R8 first line0", w, 16'h8030);
    nextWord(w);
    check("R8 second line1", w, 16'h8131);
    nextWord(w);
    check("R8 third line3", w, 16'h8333);
  endtask

  task automatic tOverrun;
    logic [15:0] w;
    setLine(0, 8'h11, 2'd3, 1'b0, 1'b0);
    setLine(1, 8'h22, 2'd3, 1'b0, 1'b0);
    pulse(4'b0011);
    setLine(1, 8'h33, 2'd3, 1'b0, 1'b0);
    pulse(4'b0010);
    idle(3);
    setLine(1, 8'h44, 2'd3, 1'b0, 1'b0);
    pulse(4'b0010);
    nextWord(w);
    check("R9 line0 clean", w, 16'h8011);
    nextWord(w);
    check("R9 line1 overrun", w, 16'hC133);
    nextWord(w);
    check("R9 line1 clean again", w, 16'h8144);
  endtask

  task automatic tFull;
    logic [15:0] w;
    for (int i = 0; i < 66; i++) begin
      setLine(2, 8'(i), 2'd3, 1'b0, 1'b0);
      pulse(4'b0100);
      idle(1);
    end
    idle(4);
    check("R4 done when full", {15'd0, rxDone}, 16'd1);
    for (int i = 0; i < 66; i++) begin
      nextWord(w);
      if (i == 65) check("R10 held char kept", w, 16'h8200 | 16'(i));
      else         check("R4 order", w, 16'h8200 | 16'(i));
    end
    idle(GAP + 4);
    readWord(w);
    check("R4 empty after drain", {15'd0, w[15]}, 16'd0);
  endtask

  task automatic tScan;
    logic [15:0] w;
    setLine(0, 8'h21, 2'd3, 1'b0, 1'b0);
    pulse(4'b0001);
    idle(1);
    setLine(0, 8'h22, 2'd3, 1'b0, 1'b0);
    pulse(4'b0001);
    idle(4);
    scanEn = 1'b0;
    idle(1);
    check("R11 done off", {15'd0, rxDone}, 16'd0);
    check("R11 valid off", {15'd0, rdWord[15]}, 16'd0);
    setLine(0, 8'h55, 2'd3, 1'b0, 1'b0);
    pulse(4'b0001);
    scanEn = 1'b1;
    idle(GAP + 6);
    check("R11 nothing after reenable", {15'd0, rxDone}, 16'd0);
    readWord(w);
    check("R11 read empty", {15'd0, w[15]}, 16'd0);
  endtask

  task automatic tClear;
    setLine(3, 8'h5A, 2'd3, 1'b1, 1'b0);
    pulse(4'b1000);
    idle(4);
    check("R12 presented before clear", rdWord, 16'hA35A);
    setLine(3, 8'h5B, 2'd3, 1'b0, 1'b0);
    pulse(4'b1000);
    idle(3);
    masterClr = 1'b1;
    idle(1);
    masterClr = 1'b0;
    check("R12 fields kept valid cleared", rdWord, 16'h235A);
    check("R12 done cleared", {15'd0, rxDone}, 16'd0);
    idle(GAP + 6);
    check("R12 queue emptied", {15'd0, rxDone}, 16'd0);
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    idle(1);
    tReset;
    idle(2);
    rstN = 1'b1;
    idle(2);
    scanEn = 1'b1;
    idle(2);
    tFormat;
    tEmpty;
    tGap;
    tArb;
    tOverrun;
    tFull;
    tScan;
    tClear;
    finishRun;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    finishRun;
  end
endmodule